// File: doc/BRIEF.md
# Transfer Command and Completion Queue Front-End

This block sits between a host register interface and a serial bus engine that runs controller-side transfers on an I3C or I2C bus. The host writes transfer command words into a command FIFO. A small sequencer takes them out in order, decodes them and hands one command at a time to the bus engine over a valid/done handshake. A command that carries a common-command code takes two FIFO entries: the first word has a flag bit set, and the second word holds the 8-bit code. The sequencer waits for that second word if it has not been written yet.

When the engine finishes a command, it returns a transferred-byte count and a 4-bit error class. The front-end packs these into a response word, pushes the word into a response FIFO and sets a completion pending bit. That bit drives the interrupt output when its mask bit is set. The host reads the free command space before it writes. It reads a status flag that shows whether responses are waiting, and it pops the responses one by one. Writing 1 and then 0 to the control register flushes all the queued state.

The sequencer has three states. In IDLE it waits for a command. NEED_CODE holds a two-word command whose code word has not arrived. ISSUE presents the command to the engine. The transitions are:
- IDLE to ISSUE when a single-word command is popped.
- IDLE to NEED_CODE when a first word with the code flag set is popped.
- NEED_CODE to ISSUE when the code word is popped.
- ISSUE to IDLE on the engine's done strobe.
- Any state to IDLE while the flush bit is held.

Top module: `i3c_cmdq_frontend`

## Requirements
- R1: A single-word command is decoded as follows, and the fields are driven on the engine outputs while `eng_valid` is high: bit 0 is read-not-write, bits 7:1 are the target address, bits 19:8 are the length, bit 20 is repeated-start and bit 21 is broadcast-header.
- R2: When bit 22 of a first word is set, the next word written supplies the 8-bit code in its bits 7:0, shown on `eng_code`. Such a command uses two command-FIFO entries.
- R3: `eng_valid` stays low while a two-word command waits for its code word. Popping the first word alone frees its entry.
- R4: The room register (word address 3) reads the number of free command entries. A command write while the FIFO is full is dropped and sets a sticky overflow flag in status bit 1.
- R5: Commands reach the engine one at a time and in write order. `eng_valid` and the fields stay steady until `eng_done`. A command is not issued while the response FIFO is full.
- R6: Each response word popped by reading word address 5 carries the engine error class in bits 23:20 and the byte count in bits 19:8; all other bits are zero. The classes are passed through unchanged: 0 none, 1 and 4 protocol errors, 6 no acknowledge, 8 unknown address.
- R7: Status bit 0 (word address 6) reads 1 exactly while the response FIFO is empty.
- R8: Pending bit 5 (word address 2) is set when a response is stored and is cleared by writing 1 to it. `irq` is high only when a pending bit and its mask bit (word address 1) are both set.
- R9: Writing 1 to control bit 0 (word address 0) holds both FIFOs, the sequencer, the pending bits and the overflow flag cleared. Writing 0 resumes normal work.
- R10: After reset, room reads 16, status reads 1, `irq` is 0 and `eng_valid` is 0. Command words are written at word address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops a response at word address 5) |
| host_addr | input | ADDR_W | Register word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Interrupt, OR of masked pending bits |
| eng_valid | output | 1 | Command presented to bus engine |
| eng_rnw | output | 1 | Read-not-write |
| eng_taddr | output | 7 | Target address |
| eng_len | output | 12 | Payload length |
| eng_rstart | output | 1 | Repeated-start request |
| eng_bcast | output | 1 | Broadcast-header request |
| eng_ccc | output | 1 | Common-command-code transfer |
| eng_code | output | 8 | Command code of a two-word command |
| eng_done | input | 1 | Engine completion strobe |
| eng_bytes | input | 12 | Bytes actually transferred |
| eng_err | input | 4 | Error class |

## Verification
The bench writes the first word of a two-word command alone and checks that nothing is issued while the code word is missing. A design that issues early would send a stale code, or would take the next command word as the code. It holds the engine, fills the command FIFO with a mix of one-word and two-word commands, and then writes once more. A design that counts entries wrongly reports the wrong room, and one that accepts the extra write corrupts queued commands or never flags the overflow. The engine model checks that commands arrive back to back in the order they were written, and that the error classes in the responses come back unchanged. Masked and unmasked completions are both used, so the tests show whether the interrupt follows the mask and whether the pending bit clears only when written with 1. A flush during a held transfer must drop everything and leave the queues working.

// File: rtl/i3c_cq_pkg.sv
package i3c_cq_pkg;
    localparam int CMD_W   = 23;
    localparam int BYTES_W = 12;
    localparam int ERR_W   = 4;
    localparam int CODE_W  = 8;
    localparam int TADDR_W = 7;

    // first command word field positions (decoded by the host side too)
    localparam int B_RNW   = 0;
    localparam int B_TADDR = 1;
    localparam int B_LEN   = 8;
    localparam int B_RSTRT = 20;
    localparam int B_BCAST = 21;
    localparam int B_CCC   = 22;

    // response word field positions
    localparam int R_BYTES = 8;
    localparam int R_ERR   = 20;

    typedef enum logic [ERR_W-1:0] {
        XERR_NONE   = 4'd0,
        XERR_PROTO0 = 4'd1,
        XERR_PROTO2 = 4'd4,
        XERR_NOACK  = 4'd6,
        XERR_NOADDR = 4'd8
    } xfer_err_e;

    typedef struct packed {
        logic               rnw;
        logic [TADDR_W-1:0] taddr;
        logic [BYTES_W-1:0] len;
        logic               rstart;
        logic               bcast;
        logic               ccc;
        logic [CODE_W-1:0]  code;
    } cmd_t;

    function automatic cmd_t decode_first(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.rnw    = w[B_RNW];
        c.taddr  = w[B_TADDR +: TADDR_W];
        c.len    = w[B_LEN +: BYTES_W];
        c.rstart = w[B_RSTRT];
        c.bcast  = w[B_BCAST];
        c.ccc    = w[B_CCC];
        c.code   = '0;
        return c;
    endfunction
endpackage

// File: rtl/i3c_cq_fifo.sv
module i3c_cq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R4: a push into a full queue changes nothing
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> count == $past(count));
    // R5: a pop of an empty queue changes nothing
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !flush |=> count == '0);
endmodule

// File: rtl/i3c_cq_seq.sv
module i3c_cq_seq
    import i3c_cq_pkg::*;
#(
    parameter int RESP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               cmd_empty,
    input  logic [CMD_W-1:0]   cmd_head,
    input  logic               resp_full,
    input  logic               eng_done,
    input  logic [BYTES_W-1:0] eng_bytes,
    input  logic [ERR_W-1:0]   eng_err,
    output logic               cmd_pop,
    output cmd_t               cmd_q,
    output logic               eng_valid,
    output logic               resp_push,
    output logic [RESP_W-1:0]  resp_word
);
    typedef enum logic [1:0] {SQ_IDLE, SQ_NEED_CODE, SQ_ISSUE} sq_state_e;
    sq_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= SQ_IDLE;
        else if (flush) state <= SQ_IDLE;
        else            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:      if (!cmd_empty && !resp_full)
                              nxt = cmd_head[B_CCC] ? SQ_NEED_CODE : SQ_ISSUE;
            SQ_NEED_CODE: if (!cmd_empty) nxt = SQ_ISSUE;
            SQ_ISSUE:     if (eng_done) nxt = SQ_IDLE;
            default:      nxt = SQ_IDLE;
        endcase
    end

    always_comb begin
        cmd_pop   = 1'b0;
        eng_valid = 1'b0;
        resp_push = 1'b0;
        unique case (state)
            SQ_IDLE:      cmd_pop   = !cmd_empty && !resp_full;
            SQ_NEED_CODE: cmd_pop   = !cmd_empty;
            SQ_ISSUE: begin
                eng_valid = 1'b1;
                resp_push = eng_done;
            end
            default: ;
        endcase
        resp_word = '0;
        resp_word[R_ERR +: ERR_W]     = eng_err;
        resp_word[R_BYTES +: BYTES_W] = eng_bytes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else if (cmd_pop && state == SQ_IDLE)      cmd_q <= decode_first(cmd_head);
        else if (cmd_pop && state == SQ_NEED_CODE) cmd_q.code <= cmd_head[CODE_W-1:0];
    end

    // R5: command held steady on the engine outputs until done
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid && !eng_done && !flush |=> eng_valid && $stable(cmd_q));
    // R3: issue only follows a pop, so a missing code word blocks it
    assert_issue_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_valid) |-> $past(cmd_pop));
endmodule

// File: rtl/i3c_cmdq_frontend.sv
module i3c_cmdq_frontend
    import i3c_cq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int CMD_DEPTH  = 16,
    parameter int RESP_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               irq,
    output logic               eng_valid,
    output logic               eng_rnw,
    output logic [TADDR_W-1:0] eng_taddr,
    output logic [BYTES_W-1:0] eng_len,
    output logic               eng_rstart,
    output logic               eng_bcast,
    output logic               eng_ccc,
    output logic [CODE_W-1:0]  eng_code,
    input  logic               eng_done,
    input  logic [BYTES_W-1:0] eng_bytes,
    input  logic [ERR_W-1:0]   eng_err
);
    localparam int CCNT_W   = $clog2(CMD_DEPTH + 1);
    localparam int RCNT_W   = $clog2(RESP_DEPTH + 1);
    localparam int DONE_BIT = 5;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_ROOM = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6);

    logic              flush_q, ovf_q;
    logic [DATA_W-1:0] mask_q, pend_q;
    logic [CCNT_W-1:0] cmd_count, cmd_room;
    logic [RCNT_W-1:0] resp_count;
    logic              cmd_empty, cmd_full, resp_empty, resp_full;
    logic              cmd_push, cmd_pop, resp_push, resp_pop;
    logic [CMD_W-1:0]  cmd_head;
    logic [DATA_W-1:0] resp_word, resp_head;
    cmd_t              cmd_q;

    assign cmd_full  = (cmd_count == CCNT_W'(CMD_DEPTH));
    assign resp_full = (resp_count == RCNT_W'(RESP_DEPTH));
    assign cmd_room  = CCNT_W'(CMD_DEPTH) - cmd_count;
    assign cmd_push  = host_wr && host_addr == A_CMD && !flush_q;
    assign resp_pop  = host_rd && host_addr == A_RESP && !flush_q;

    i3c_cq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(cmd_push), .pop(cmd_pop), .wdata(host_wdata[CMD_W-1:0]),
        .rdata(cmd_head), .count(cmd_count), .empty(cmd_empty)
    );

    i3c_cq_fifo #(.WIDTH(DATA_W), .DEPTH(RESP_DEPTH)) u_resp_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(resp_push), .pop(resp_pop), .wdata(resp_word),
        .rdata(resp_head), .count(resp_count), .empty(resp_empty)
    );

    i3c_cq_seq #(.RESP_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head), .resp_full(resp_full),
        .eng_done(eng_done), .eng_bytes(eng_bytes), .eng_err(eng_err),
        .cmd_pop(cmd_pop), .cmd_q(cmd_q), .eng_valid(eng_valid),
        .resp_push(resp_push), .resp_word(resp_word)
    );

    assign eng_rnw    = cmd_q.rnw;
    assign eng_taddr  = cmd_q.taddr;
    assign eng_len    = cmd_q.len;
    assign eng_rstart = cmd_q.rstart;
    assign eng_bcast  = cmd_q.bcast;
    assign eng_ccc    = cmd_q.ccc;
    assign eng_code   = cmd_q.code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            mask_q  <= '0;
            pend_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (host_wr && host_addr == A_CTRL) flush_q <= host_wdata[0];
            if (host_wr && host_addr == A_MASK) mask_q  <= host_wdata;
            if (flush_q) begin
                pend_q <= '0;
                ovf_q  <= 1'b0;
            end else begin
                if (cmd_push && cmd_full) ovf_q <= 1'b1;
                pend_q <= (pend_q & ~((host_wr && host_addr == A_PEND) ? host_wdata : '0))
                          | (DATA_W'(resp_push) << DONE_BIT);
            end
        end
    end

    assign irq = |(pend_q & mask_q);

    always_comb begin
        unique case (host_addr)
            A_CTRL:  host_rdata = DATA_W'(flush_q);
            A_MASK:  host_rdata = mask_q;
            A_PEND:  host_rdata = pend_q;
            A_ROOM:  host_rdata = DATA_W'(cmd_room);
            A_RESP:  host_rdata = resp_empty ? '0 : resp_head;
            A_STAT:  host_rdata = DATA_W'({ovf_q, resp_empty});
            default: host_rdata = '0;
        endcase
    end

    // R8: the completion pending bit only rises after a stored response
    assert_pend_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[DONE_BIT]) |-> $past(resp_push));
    // R7: a stored response clears the empty flag
    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_push && !flush_q |=> !resp_empty);
    // R4: overflow flag only set by a write into a full queue
    assert_ovf_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(cmd_full && cmd_push));
endmodule

// File: tb/i3c_cmdq_frontend_tb.sv
`timescale 1ns/1ps
module i3c_cmdq_frontend_tb;
    import i3c_cq_pkg::*;

    localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_PEND = 3'd2,
                           A_ROOM = 3'd3, A_CMD  = 3'd4, A_RESP = 3'd5, A_STAT = 3'd6;

    logic clk = 0, rst_n = 0;
    logic host_wr = 0, host_rd = 0;
    logic [2:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic irq, eng_valid, eng_rnw, eng_rstart, eng_bcast, eng_ccc;
    logic [6:0] eng_taddr;
    logic [11:0] eng_len;
    logic [7:0] eng_code;
    logic eng_done = 0;
    logic [11:0] eng_bytes = '0;
    logic [3:0] eng_err = '0;

    always #2.5 clk = ~clk;

    i3c_cmdq_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .eng_valid(eng_valid), .eng_rnw(eng_rnw), .eng_taddr(eng_taddr),
        .eng_len(eng_len), .eng_rstart(eng_rstart), .eng_bcast(eng_bcast),
        .eng_ccc(eng_ccc), .eng_code(eng_code), .eng_done(eng_done),
        .eng_bytes(eng_bytes), .eng_err(eng_err)
    );

    typedef struct {
        bit rnw; bit [6:0] ta; bit [11:0] len; bit sr, bc, ccc;
        bit [7:0] code; bit [11:0] rb; bit [3:0] re;
    } item_t;

    item_t exp_cmd[$];
    logic [31:0] exp_resp[$];
    int checks = 0, errors = 0;
    bit hold = 0, finished = 0;
    int wait_cnt = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1;
        #0.5 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    function automatic logic [31:0] word0(item_t it);
        logic [31:0] w = '0;
        w[B_RNW] = it.rnw; w[B_TADDR +: 7] = it.ta; w[B_LEN +: 12] = it.len;
        w[B_RSTRT] = it.sr; w[B_BCAST] = it.bc; w[B_CCC] = it.ccc;
        return w;
    endfunction

    task automatic send(item_t it);
        exp_cmd.push_back(it);
        reg_write(A_CMD, word0(it));
        if (it.ccc) reg_write(A_CMD, {24'h0, it.code});
    endtask

    task automatic drain(int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            int tries = 0;
            reg_read(A_STAT, d);
            while (d[0] && tries < 200) begin
                reg_read(A_STAT, d);
                tries++;
            end
            reg_read(A_RESP, d);
            if (exp_resp.size() == 0) chk("R6", "unexpected response", d, 32'hx);
            else chk("R6", "response word", d, exp_resp.pop_front());
        end
    endtask

    // engine model and command monitor
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 0;
            if (eng_valid && !hold) begin
                if (wait_cnt == 2) begin
                    item_t it;
                    wait_cnt = 0;
                    if (exp_cmd.size() == 0) begin
                        chk("R5", "issue with empty scoreboard", 32'd1, 32'd0);
                    end else begin
                        it = exp_cmd.pop_front();
                        chk("R1", "rnw", 32'(eng_rnw), 32'(it.rnw));
                        chk("R1", "taddr", 32'(eng_taddr), 32'(it.ta));
                        chk("R1", "len", 32'(eng_len), 32'(it.len));
                        chk("R1", "rstart/bcast", {30'h0, eng_rstart, eng_bcast}, {30'h0, it.sr, it.bc});
                        chk("R2", "ccc flag", 32'(eng_ccc), 32'(it.ccc));
                        if (it.ccc) chk("R2", "code", 32'(eng_code), 32'(it.code));
                        eng_bytes = it.rb; eng_err = it.re; eng_done = 1;
                        exp_resp.push_back({8'h0, it.re, it.rb, 8'h0});
                    end
                end else wait_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        item_t it;
        repeat (5) @(posedge clk);
        rst_n = 1;

        // R10 reset state
        reg_read(A_ROOM, d); chk("R10", "room after reset", d, 32'd16);
        reg_read(A_STAT, d); chk("R10", "status after reset", d, 32'd1);
        chk("R10", "irq after reset", 32'(irq), 32'd0);
        chk("R10", "valid after reset", 32'(eng_valid), 32'd0);

        reg_write(A_MASK, 32'h20);

        // R1 plain write, R7 empty flag, R8 interrupt
        it = '{rnw:0, ta:7'h2A, len:12'd5, sr:1, bc:0, ccc:0, code:0, rb:12'd5, re:4'd0};
        send(it);
        repeat (12) @(posedge clk);
        reg_read(A_STAT, d); chk("R7", "status with response waiting", d, 32'd0);
        chk("R8", "irq when masked-in pending", 32'(irq), 32'd1);
        drain(1);
        reg_read(A_STAT, d); chk("R7", "status after drain", d, 32'd1);
        reg_read(A_PEND, d); chk("R8", "pending bit 5", d, 32'h20);
        reg_write(A_PEND, 32'h20);
        reg_read(A_PEND, d); chk("R8", "pending after W1C", d, 32'h0);
        chk("R8", "irq after W1C", 32'(irq), 32'd0);

        // R3 two-word command with late code word
        it = '{rnw:1, ta:7'h7E, len:12'd2, sr:0, bc:1, ccc:1, code:8'h8F, rb:12'd2, re:4'd6};
        exp_cmd.push_back(it);
        reg_write(A_CMD, word0(it));
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R3", "valid while code missing", 32'(eng_valid), 32'd0);
        reg_read(A_ROOM, d); chk("R3", "room after first word popped", d, 32'd16);
        reg_write(A_CMD, {24'h0, it.code});
        drain(1);

        // R5 burst in order, R6 error classes
        it = '{rnw:0, ta:7'h10, len:12'd3, sr:1, bc:1, ccc:0, code:0, rb:12'd1, re:4'd1};  send(it);
        it = '{rnw:1, ta:7'h11, len:12'd4, sr:0, bc:0, ccc:1, code:8'h2C, rb:12'd4, re:4'd4}; send(it);
        it = '{rnw:1, ta:7'h12, len:12'hFFF, sr:1, bc:0, ccc:0, code:0, rb:12'hABC, re:4'd8}; send(it);
        it = '{rnw:0, ta:7'h00, len:12'd0, sr:0, bc:1, ccc:1, code:8'h06, rb:12'd0, re:4'd0}; send(it);
        drain(4);
        reg_write(A_PEND, 32'h20);

        // R8 masked-out completion
        reg_write(A_MASK, 32'h0);
        it = '{rnw:0, ta:7'h33, len:12'd1, sr:0, bc:0, ccc:0, code:0, rb:12'd1, re:4'd0}; send(it);
        drain(1);
        chk("R8", "irq with mask clear", 32'(irq), 32'd0);
        reg_read(A_PEND, d); chk("R8", "pending set while masked", d, 32'h20);
        reg_write(A_PEND, 32'h20);

        // R2/R4 room accounting and overflow, R9 flush
        hold = 1;
        it = '{rnw:0, ta:7'h44, len:12'd1, sr:0, bc:0, ccc:0, code:0, rb:12'd1, re:4'd0}; send(it);
        for (int i = 0; i < 50 && !eng_valid; i++) @(negedge clk);
        reg_read(A_ROOM, d); chk("R4", "room with one in flight", d, 32'd16);
        reg_write(A_CMD, 32'h0040_0100);
        reg_write(A_CMD, 32'h0000_0055);
        reg_read(A_ROOM, d); chk("R2", "two entries for coded command", d, 32'd14);
        for (int i = 0; i < 14; i++) reg_write(A_CMD, 32'h0000_0102);
        reg_read(A_ROOM, d); chk("R4", "room when full", d, 32'd0);
        reg_write(A_CMD, 32'h0000_0104);
        reg_read(A_ROOM, d); chk("R4", "room after dropped write", d, 32'd0);
        reg_read(A_STAT, d); chk("R4", "overflow flag", d, 32'd3);
        reg_write(A_CTRL, 32'd1);
        reg_write(A_CTRL, 32'd0);
        exp_cmd.delete();
        hold = 0;
        reg_read(A_ROOM, d); chk("R9", "room after flush", d, 32'd16);
        reg_read(A_STAT, d); chk("R9", "status after flush", d, 32'd1);
        chk("R9", "valid after flush", 32'(eng_valid), 32'd0);
        it = '{rnw:1, ta:7'h55, len:12'd7, sr:0, bc:0, ccc:0, code:0, rb:12'd7, re:4'd0}; send(it);
        drain(1);
        chk("R9", "scoreboard empty after resume", 32'(exp_cmd.size() + exp_resp.size()), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule